// File: doc/BRIEF.md
# Cascaded Multiply-Add Transposed FIR Filter

This block is a transposed-form FIR filter. It is built from a chain of identical multiply-add cells. Each cell keeps one 12-bit signed weight and registers the incoming 12-bit signed sample. It multiplies the two, adds the product to the partial sum handed on by its upstream neighbour, and registers the result for the next cell. Every cell receives the same sample in the same clock. The last cell in the chain produces one filtered value per clock.

A two-state controller decides when the datapath runs. In state `ST_IDLE` the weights can be written one tap at a time, and the sample and sum registers are flushed to zero. In state `ST_RUN` the filter streams and every weight is frozen. There are two transitions. `GO` moves from `ST_IDLE` to `ST_RUN` on a clock edge where `run` is high. `HALT` moves from `ST_RUN` to `ST_IDLE` on an edge where `run` is low. Synchronous reset forces `ST_IDLE`.

Top module: `fir_mac_cascade`

## Requirements
- R1: In `ST_IDLE`, a clock edge with `coef_we` high and `coef_sel` = k (k < TAPS) loads `coef_val` as weight h_k. The cell for h0 is last in the chain and the cell for h(TAPS-1) is first. No other weight changes.
- R2: While the controller is in `ST_RUN`, `coef_we` is ignored, so the weights in use stay unchanged.
- R3: A write with `coef_sel` >= TAPS changes no weight, even in `ST_IDLE`.
- R4: Synchronous reset (`rst` high at an edge) zeroes `y_out` and all sample and sum registers, and leaves every weight as it was.
- R5: The controller moves to `ST_RUN` on an edge with `run` high and back to `ST_IDLE` on an edge with `run` low. While it is in `ST_IDLE`, the datapath registers clear, so `y_out` reads 0 from the second idle edge onward.
- R6: While running, the output after each edge is y = sum over k of h_k * x(n-1-k). Here x(n) is the sample captured at the current edge, so a sample first appears at the output after the edge that follows its capture (2-clock latency). Samples from before entry into `ST_RUN` count as zero.
- R7: The arithmetic is signed two's complement at full precision. `y_out` is 12+12+ceil(log2 TAPS) bits wide (27 for 5 taps) and never overflows, even when every sample and every weight is -2048.
- R8: In `ST_RUN` a new output is produced on every clock, with no stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Request to stream (high) or to stop (low) |
| coef_we | input | 1 | Weight write strobe |
| coef_sel | input | SELW (3) | Index k of the weight h_k to write |
| coef_val | input | CW (12) | Signed weight value |
| samp_in | input | DW (12) | Signed input sample, sent to all cells |
| y_out | output | SW (27) | Signed filter output |

## Verification
The bench checks the impulse response tap by tap. A design that reversed the chain order or added a register stage would show the weights in the wrong order or one clock late. Steps of extreme negative samples against extreme negative weights catch a sum path that is too narrow or extended without sign, because the output would wrap to a wrong sign. Weight writes issued while streaming, or with an out-of-range index, are followed by an impulse that exposes any weight that moved. A reset in the middle of the stream checks that the weights survive while the sums clear. Random streams compared against a direct convolution catch wrong products or a broken partial-sum handoff.

// File: rtl/fir_pkg.sv
package fir_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fir_state_e;
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
    import fir_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic dp_run,
    output logic wr_open
);
    fir_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run)  state_d = ST_RUN;   // GO
            ST_RUN:  if (!run) state_d = ST_IDLE;  // HALT
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        dp_run  = 1'b0;
        wr_open = 1'b0;
        unique case (state_q)
            ST_IDLE: wr_open = 1'b1;
            ST_RUN:  dp_run  = 1'b1;
            default: ;
        endcase
    end

    // R5
    go_transition_chk: assert property (@(posedge clk) disable iff (rst)
        (!dp_run && run) |=> dp_run);
    // R5
    halt_transition_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_run && !run) |=> !dp_run);
endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell #(
    parameter int DW     = 12,
    parameter int CW     = 12,
    parameter int SW     = 27,
    parameter int SELW   = 3,
    parameter int TAP_ID = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dp_run,
    input  logic                 wr_open,
    input  logic                 coef_we,
    input  logic [SELW-1:0]      coef_sel,
    input  logic signed [CW-1:0] coef_val,
    input  logic signed [DW-1:0] samp,
    input  logic signed [SW-1:0] sum_in,
    output logic signed [SW-1:0] sum_out
);
    localparam int PW = DW + CW;

    logic signed [CW-1:0] wt_q;
    logic signed [DW-1:0] smp_q;
    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] prod_ext;
    logic signed [SW-1:0] acc_q;
    logic                 hit;

    assign hit = wr_open && coef_we && (coef_sel == SELW'(TAP_ID));

    // weight register: never reset, written only through the idle window
    always_ff @(posedge clk) begin
        if (hit) wt_q <= coef_val;
    end

    assign prod     = smp_q * wt_q;
    assign prod_ext = {{(SW-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst || !dp_run) begin
            smp_q <= '0;
            acc_q <= '0;
        end else begin
            smp_q <= samp;
            acc_q <= sum_in + prod_ext;
        end
    end

    assign sum_out = acc_q;

    // R2
    coef_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        dp_run |=> $stable(wt_q));
    // R6
    sample_capture_chk: assert property (@(posedge clk) disable iff (rst)
        dp_run |=> smp_q == $past(samp));
    // R5
    idle_flush_chk: assert property (@(posedge clk) disable iff (rst)
        !dp_run |=> (acc_q == '0 && smp_q == '0));
endmodule

// File: rtl/fir_mac_cascade.sv
module fir_mac_cascade #(
    parameter int TAPS = 5,
    parameter int DW   = 12,
    parameter int CW   = 12,
    parameter int GB   = (TAPS > 1) ? $clog2(TAPS) : 1,
    parameter int SW   = DW + CW + GB,
    parameter int SELW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 coef_we,
    input  logic [SELW-1:0]      coef_sel,
    input  logic signed [CW-1:0] coef_val,
    input  logic signed [DW-1:0] samp_in,
    output logic signed [SW-1:0] y_out
);
    logic dp_run;
    logic wr_open;
    logic signed [SW-1:0] chain [TAPS+1];

    fir_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .dp_run  (dp_run),
        .wr_open (wr_open)
    );

    assign chain[0] = '0;

    for (genvar p = 0; p < TAPS; p++) begin : g_cell
        fir_mac_cell #(
            .DW     (DW),
            .CW     (CW),
            .SW     (SW),
            .SELW   (SELW),
            .TAP_ID (TAPS - 1 - p)
        ) u_cell (
            .clk      (clk),
            .rst      (rst),
            .dp_run   (dp_run),
            .wr_open  (wr_open),
            .coef_we  (coef_we),
            .coef_sel (coef_sel),
            .coef_val (coef_val),
            .samp     (samp_in),
            .sum_in   (chain[p]),
            .sum_out  (chain[p+1])
        );
    end

    assign y_out = chain[TAPS];

    // R4
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> y_out == '0);
endmodule

// File: tb/test_fir_mac_cascade.sv
module test_fir_mac_cascade;
    localparam int TAPS = 5;
    localparam int DW   = 12;
    localparam int CW   = 12;
    localparam int SW   = 27;
    localparam int SELW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic coef_we = 1'b0;
    logic [SELW-1:0] coef_sel = '0;
    logic signed [CW-1:0] coef_val = '0;
    logic signed [DW-1:0] samp_in = '0;
    logic signed [SW-1:0] y_out;

    int n_tests = 0;
    int n_fail  = 0;
    int h_m  [TAPS];
    int hist [TAPS+1];
    bit done = 1'b0;

    always #5 clk = ~clk;

    fir_mac_cascade i_fir_mac_cascade (
        .clk(clk), .rst(rst), .run(run), .coef_we(coef_we),
        .coef_sel(coef_sel), .coef_val(coef_val),
        .samp_in(samp_in), .y_out(y_out)
    );

    function automatic int exp_y();
        int acc = 0;
        for (int k = 0; k < TAPS; k++) acc += h_m[k] * hist[k+1];
        return acc;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i <= TAPS; i++) hist[i] = 0;
    endtask

    // one running clock: sample x, optional write attempt (must be ignored, R2)
    task automatic step(input int x, input string req, input bit we = 0,
                        input int sel = 0, input int val = 0);
        @(negedge clk);
        samp_in  = DW'(x);
        coef_we  = we;
        coef_sel = SELW'(sel);
        coef_val = CW'(val);
        @(posedge clk); #1;
        coef_we = 1'b0;
        for (int i = TAPS; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        check(req, int'(y_out), exp_y());
    endtask

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        coef_we = 1'b1; coef_sel = SELW'(sel); coef_val = CW'(val);
        @(posedge clk); #1;
        coef_we = 1'b0;
        if (sel < TAPS) h_m[sel] = val;
    endtask

    task automatic go_idle();
        @(negedge clk); run = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R5 idle flush", int'(y_out), 0);
        clear_hist();
    endtask

    task automatic go_run();
        @(negedge clk); run = 1'b1; samp_in = '0;
        @(posedge clk); #1;
        clear_hist();
    endtask

    task automatic impulse(input string req);
        step(1, req);
        for (int i = 0; i < TAPS + 1; i++) step(0, req);
    endtask

    initial begin
        void'($urandom(32'd4242));
        clear_hist();
        repeat (3) @(posedge clk);
        #1 check("R4 reset output", int'(y_out), 0);
        @(negedge clk) rst = 1'b0;

        // R1: load distinct weights per index
        wr(0, 11); wr(1, -7); wr(2, 300); wr(3, -2048); wr(4, 2047);
        go_run();
        impulse("R1/R6 impulse ordering");
        // R8: step response, one new value every clock
        for (int i = 0; i < 8; i++) step(100, "R8 step");
        // R2: write attempts during streaming
        step(0, "R2 write in run", 1, 2, 999);
        step(0, "R2 write in run", 1, 0, -5);
        impulse("R2 weights unchanged");

        // R3: out-of-range index in idle
        go_idle();
        wr(5, 1234); wr(7, -1234);
        go_run();
        impulse("R3 bad index ignored");

        // R7: extreme values
        go_idle();
        for (int k = 0; k < TAPS; k++) wr(k, -2048);
        go_run();
        for (int i = 0; i < 7; i++) step(-2048, "R7 extreme neg");
        for (int i = 0; i < 7; i++) step(2047, "R7 extreme mixed");

        // R6: random weights and random stream
        go_idle();
        for (int k = 0; k < TAPS; k++) wr(k, int'($signed(CW'($urandom))));
        go_run();
        for (int i = 0; i < 300; i++) step(int'($signed(DW'($urandom))), "R6 random");

        // R4: reset mid-stream keeps weights
        @(negedge clk); rst = 1'b1; run = 1'b0;
        @(posedge clk); #1;
        check("R4 reset clears", int'(y_out), 0);
        @(negedge clk); rst = 1'b0;
        go_run();
        impulse("R4 weights kept");
        for (int i = 0; i < 50; i++) step(int'($signed(DW'($urandom))), "R6 random after reset");
        go_idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule